// File: doc/BRIEF.md
# Triple-Stream CRC-Checked Majority Receiver

This block sits at the far end of a link that carries the same 16-bit payload over three independent copies. Every copy arrives as a 32-bit word: the payload sits in the upper half and a CRC-16 check value, which the sender computed over that payload, sits in the lower half. On each accepted input cycle the block recomputes the check value for all three copies in parallel. It marks each copy whose recomputed value differs from the received one, and then votes among the copies that survived the check to produce a single corrected payload.

Copies that fail their check take no part in the vote. Two surviving copies that agree win the vote. A lone survivor is passed on with a degraded warning. When no trustworthy value can be formed, the block outputs the sentinel 0xDEAD and raises an error flag. All results are registered, so each result appears one clock after its input, together with a 3-bit mask that shows which copies failed their check.

Top module: `tmr_crc_rx`

## Requirements
- R1: For stream i, bit i of `out_crc_bad` is 1 exactly when the recomputed CRC over bits [31:16] differs from bits [15:0]. The CRC uses generator 0x1021 with a 0xFFFF preset and takes data bits most significant first, with no reflection and no final XOR.
- R2: `out_valid` is high in the cycle after `in_valid` was high and low in the cycle after `in_valid` was low. The result fields belong to the input that was accepted on that edge.
- R3: When all three streams pass and at least two of their data fields are equal, `out_data` is that common value and `out_err` and `out_degraded` are 0.
- R4: When exactly two streams pass and their data fields are equal, `out_data` is that value and `out_err` and `out_degraded` are 0.
- R5: When exactly one stream passes, `out_data` is its data field, `out_degraded` is 1 and `out_err` is 0. `out_err` and `out_degraded` are never high together.
- R6: When no stream passes, `out_data` is 0xDEAD and `out_err` is 1.
- R7: When two passing streams disagree, or when three passing streams are all different, `out_data` is 0xDEAD and `out_err` is 1.
- R8: The data field of a stream that fails its CRC has no effect on `out_data`, even when two failing streams carry equal data.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_err`, `out_degraded`, `out_crc_bad` and `out_data` to 0.
- R10: While `in_valid` is low, `out_data`, `out_err`, `out_degraded` and `out_crc_bad` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The three words are present this cycle |
| in_word0 | input | 32 | Stream 0: data [31:16], CRC [15:0] |
| in_word1 | input | 32 | Stream 1: data [31:16], CRC [15:0] |
| in_word2 | input | 32 | Stream 2: data [31:16], CRC [15:0] |
| out_valid | output | 1 | A result is present this cycle |
| out_data | output | 16 | Voted data, or 0xDEAD on error |
| out_err | output | 1 | No trustworthy value could be formed |
| out_degraded | output | 1 | The result rests on a single passing stream |
| out_crc_bad | output | 3 | Bit i set when stream i failed its CRC |

## Verification
The assertions assume that `in_valid` and the three words are stable around each rising edge and are never X while `in_valid` is high. They also assume that a flagged error always comes with the sentinel value. The stimulus changes its inputs only on falling edges and holds `in_valid` low across the reset. It sweeps every one of the eight CRC-failure masks against five patterns of data agreement over many payloads, and corrupts a check field by a nonzero XOR so that the intended mask is exact.

// File: rtl/tmr_rx_pkg.sv
package tmr_rx_pkg;
    localparam int DATA_W    = 16;
    localparam int CRC_W     = 16;
    localparam int WORD_W    = DATA_W + CRC_W;
    localparam int N_STREAMS = 3;
    localparam logic [CRC_W-1:0]  CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF;
    localparam logic [DATA_W-1:0] ERR_CODE = 16'hDEAD;

    typedef struct packed {
        logic                 valid;
        logic [DATA_W-1:0]    data;
        logic                 err;
        logic                 degraded;
        logic [N_STREAMS-1:0] crc_bad;
    } rx_state_t;
endpackage

// File: rtl/tmr_crc_lane.sv
module tmr_crc_lane #(
    parameter int DATA_W = 16,
    parameter int CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021,
    parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
    input  logic [DATA_W+CRC_W-1:0] word_i,
    output logic [DATA_W-1:0]       data_o,
    output logic                    bad_o
);
    localparam int WORD_W = DATA_W + CRC_W;

    logic [CRC_W-1:0] rx_crc;
    logic [CRC_W-1:0] calc_crc;

    assign data_o = word_i[WORD_W-1:CRC_W];
    assign rx_crc = word_i[CRC_W-1:0];

    // Unrolled bit-serial LFSR, one step per data bit, MSB first.
    always_comb begin
        logic [CRC_W-1:0] r;
        logic             fb;
        r = INIT;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ data_o[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        calc_crc = r;
    end

    assign bad_o = (calc_crc != rx_crc);
endmodule

// File: rtl/tmr_vote.sv
module tmr_vote #(
    parameter int DATA_W = 16,
    parameter int N      = 3,
    parameter logic [DATA_W-1:0] ERR_CODE = 16'hDEAD
) (
    input  logic [N-1:0][DATA_W-1:0] data_i,
    input  logic [N-1:0]             pass_i,
    output logic [DATA_W-1:0]        data_o,
    output logic                     err_o,
    output logic                     deg_o
);
    localparam int CNT_W = $clog2(N + 1);

    // agree[i][j]: streams i and j both passed and carry equal data
    logic [N-1:0][N-1:0] agree;
    logic [N-1:0]        backed;
    logic [CNT_W-1:0]    n_pass;

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_self
                assign agree[i][j] = 1'b0;
            end else begin : g_pair
                assign agree[i][j] = pass_i[i] & pass_i[j] &
                                     (data_i[i] == data_i[j]);
            end
        end
        assign backed[i] = |agree[i];
    end

    always_comb begin
        n_pass = '0;
        for (int i = 0; i < N; i++) begin
            n_pass = n_pass + CNT_W'(pass_i[i]);
        end
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        data_o = ERR_CODE;
        err_o  = 1'b0;
        deg_o  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && backed[i]) begin
                found  = 1'b1;
                data_o = data_i[i];
            end
        end
        if (!found) begin
            if (n_pass == CNT_W'(1)) begin
                deg_o = 1'b1;
                for (int i = 0; i < N; i++) begin
                    if (pass_i[i]) data_o = data_i[i];
                end
            end else begin
                err_o  = 1'b1;
                data_o = ERR_CODE;
            end
        end
    end
endmodule

// File: rtl/tmr_crc_rx.sv
module tmr_crc_rx
    import tmr_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word0,
    input  logic [WORD_W-1:0] in_word1,
    input  logic [WORD_W-1:0] in_word2,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err,
    output logic              out_degraded,
    output logic [N_STREAMS-1:0] out_crc_bad
);
    logic [N_STREAMS-1:0][WORD_W-1:0] words;
    logic [N_STREAMS-1:0][DATA_W-1:0] lane_data;
    logic [N_STREAMS-1:0]             lane_bad;
    logic [DATA_W-1:0]                vote_data;
    logic                             vote_err;
    logic                             vote_deg;

    assign words[0] = in_word0;
    assign words[1] = in_word1;
    assign words[2] = in_word2;

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_lane
        tmr_crc_lane #(
            .DATA_W (DATA_W),
            .CRC_W  (CRC_W),
            .POLY   (CRC_POLY),
            .INIT   (CRC_INIT)
        ) lane_i (
            .word_i (words[s]),
            .data_o (lane_data[s]),
            .bad_o  (lane_bad[s])
        );
    end

    tmr_vote #(
        .DATA_W   (DATA_W),
        .N        (N_STREAMS),
        .ERR_CODE (ERR_CODE)
    ) vote_i (
        .data_i (lane_data),
        .pass_i (~lane_bad),
        .data_o (vote_data),
        .err_o  (vote_err),
        .deg_o  (vote_deg)
    );

    rx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.data     = vote_data;
            st_d.err      = vote_err;
            st_d.degraded = vote_deg;
            st_d.crc_bad  = lane_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign out_data     = st_q.data;
    assign out_err      = st_q.err;
    assign out_degraded = st_q.degraded;
    assign out_crc_bad  = st_q.crc_bad;

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_status_capture_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_crc_bad == $past(lane_bad));
    assert_err_sentinel_R6: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_data == ERR_CODE);
    assert_all_bad_err_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&lane_bad)) |=> out_err);
    assert_err_deg_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(out_err && out_degraded));
    assert_deg_single_R5: assert property (@(posedge clk) disable iff (rst)
        out_degraded |-> $countones(out_crc_bad) == N_STREAMS - 1);
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data) && $stable(out_err) &&
                      $stable(out_degraded) && $stable(out_crc_bad));
    assert_reset_R9: assert property (@(posedge clk)
        rst |=> !out_valid && !out_err && !out_degraded && out_crc_bad == '0);
endmodule

// File: tb/tmr_crc_rx_tb_top.sv
module tmr_crc_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] w0 = '0, w1 = '0, w2 = '0;
    logic        out_valid, out_err, out_degraded;
    logic [15:0] out_data;
    logic [2:0]  out_crc_bad;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tmr_crc_rx dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_word0(w0), .in_word1(w1), .in_word2(w2),
        .out_valid(out_valid), .out_data(out_data), .out_err(out_err),
        .out_degraded(out_degraded), .out_crc_bad(out_crc_bad)
    );

    // Reference CRC, computed as polynomial division of data*x^16 plus preset term
    function automatic logic [15:0] ref_crc(input logic [15:0] d);
        logic [31:0] acc;
        acc = {d ^ 16'hFFFF, 16'h0000};
        for (int k = 31; k >= 16; k--) begin
            if (acc[k]) acc[k -: 17] = acc[k -: 17] ^ 17'h11021;
        end
        return acc[15:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [15:0] d0, d1, d2, input logic [2:0] badmask);
        logic [15:0] dd [3];
        logic [15:0] exp_d;
        logic        exp_e, exp_g;
        int          np;
        string       tag;
        dd[0] = d0; dd[1] = d1; dd[2] = d2;
        w0 = {d0, ref_crc(d0) ^ (badmask[0] ? 16'h0400 : 16'h0)};
        w1 = {d1, ref_crc(d1) ^ (badmask[1] ? 16'h8001 : 16'h0)};
        w2 = {d2, ref_crc(d2) ^ (badmask[2] ? 16'h0010 : 16'h0)};
        in_valid = 1'b1;
        np = 3 - $countones(badmask);
        exp_e = 1'b0; exp_g = 1'b0; exp_d = 16'hDEAD;
        if (np == 0) begin
            exp_e = 1'b1; tag = "R6";
        end else if (np == 1) begin
            exp_g = 1'b1; tag = "R5/R8";
            for (int s = 0; s < 3; s++) if (!badmask[s]) exp_d = dd[s];
        end else if (np == 2) begin
            logic [15:0] a, b;
            a = badmask[0] ? dd[1] : dd[0];
            b = badmask[2] ? dd[1] : dd[2];
            if (a == b) begin exp_d = a; tag = "R4/R8"; end
            else begin exp_e = 1'b1; tag = "R7"; end
        end else begin
            if (d0 == d1 || d0 == d2) begin exp_d = d0; tag = "R3"; end
            else if (d1 == d2) begin exp_d = d1; tag = "R3"; end
            else begin exp_e = 1'b1; tag = "R7"; end
        end
        @(negedge clk);
        check("R2 valid", {31'b0, out_valid}, 32'd1);
        check("R1 crc_bad", {29'b0, out_crc_bad}, {29'b0, badmask});
        check({tag, " data"}, {16'b0, out_data}, {16'b0, exp_d});
        check({tag, " err/deg"}, {30'b0, out_err, out_degraded}, {30'b0, exp_e, exp_g});
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] base, alt;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset", {out_valid, out_err, out_degraded, out_crc_bad, out_data},
              32'h0);
        rst = 1'b0;
        for (int seed = 0; seed < 24; seed++) begin
            base = 16'(seed * 16'h2F57 + 16'h0133);
            for (int m = 0; m < 8; m++) begin
                for (int a = 0; a < 5; a++) begin
                    alt = base ^ 16'(16'h0101 * (a + 1));
                    case (a)
                        0: run_vec(base, base, base, 3'(m));
                        1: run_vec(alt,  base, base, 3'(m));
                        2: run_vec(base, alt,  base, 3'(m));
                        3: run_vec(base, base, alt,  3'(m));
                        default: run_vec(base, base ^ 16'h0001, base ^ 16'h0002, 3'(m));
                    endcase
                end
            end
        end
        // R8: two failing streams agree, lone passing stream wins
        run_vec(16'h1234, 16'h5555, 16'h5555, 3'b110);
        check("R8 ignore failing", {16'b0, out_data}, 32'h1234);
        // R10: hold while in_valid low, with changed inputs
        run_vec(16'hBEEF, 16'hBEEF, 16'h0000, 3'b100);
        in_valid = 1'b0;
        w0 = 32'h0; w1 = 32'hFFFF_FFFF; w2 = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check("R10 valid low", {31'b0, out_valid}, 32'd0);
        check("R10 hold", {out_err, out_degraded, out_crc_bad, 11'b0, out_data},
              {5'b00100, 11'b0, 16'hBEEF});
        // R9: reset after an error result
        run_vec(16'h1, 16'h2, 16'h3, 3'b111);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 reset after err", {out_valid, out_err, out_degraded, out_crc_bad, out_data},
              32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule